// File: doc/BRIEF.md
# Sample Voice Dispatcher

This block sits between game logic and a four-voice sample playback device. It takes one sound request at a time and turns it into a short burst of byte writes for that device. It decides which voice gets the sound from the device's voice-busy status. A request carries a music flag and an 8-bit code. Codes below 0x80 start a sample. Codes at 0x80 and above stop playback.

Sound effects go to the lowest-numbered idle voice among voices one to three. Music always uses voice four. Starting a new piece of music also starts a periodic sequencing tick, which downstream logic uses to step through the bars of the music. The block keeps the number of the piece now playing and a bar register. A start sets the bar register to one, and a music stop clears both. The tick timing is set by two cycle-count parameters: the delay to the first tick and the tick period. At a 200 MHz clock, a 250 Hz rate with a 4 ms first delay is 800000 cycles for each.

Top module: `snd_voice_dispatch`

## Requirements
- R1: After reset, `ready` is 1, `wr_en` is 0, `tick` is 0, and `track_no` and `bar_no` are 0.
- R2: A request with `req_code[7]`=1 produces exactly one write, whose data is `req_code` with bit 7 cleared. This holds whatever `req_track` is.
- R3: An effect start (`req_track`=0, `req_code` < 0x80) checks `voice_busy` bits 0, 1 and 2 in that priority order and takes the first clear one. It writes 0x80 OR the sample number, then a voice byte. The voice byte is 0x11 for bit 0, 0x21 for bit 1 and 0x41 for bit 2.
- R4: An effect start while `voice_busy[2:0]` is all ones produces no write, and `ready` stays 1.
- R5: A music start (`req_track`=1, `req_code` < 0x80) whose number differs from `track_no` works as follows. If `voice_busy[3]` is 1, it first writes 0x40. It then writes 0x80 OR the number, followed by 0x81. From the next cycle on, `track_no` holds the number and `bar_no` is 1.
- R6: A music start whose number equals `track_no` produces no write and changes neither `track_no`, `bar_no` nor the tick timing.
- R7: A music stop (`req_track`=1, `req_code[7]`=1) halts the tick and sets `track_no` and `bar_no` to 0 from the next cycle on.
- R8: After an accepted R5 start, `tick` pulses high for one cycle, FIRST_TICK_CYC cycles after the accepting edge. It then pulses every TICK_PERIOD_CYC cycles until an R7 stop. A later R5 start restarts this timing.
- R9: A request is accepted only on an edge where `ready` is 1. The writes of an accepted request appear on consecutive cycles starting the cycle after acceptance, and `ready` is 0 while they are pending. Requests presented while `ready` is 0 are ignored.
- R10: `voice_busy` is sampled only on the accepting edge. Later changes do not alter the writes of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_track | input | 1 | 1 = music request (voice four), 0 = effect |
| req_code | input | 8 | Bit 7 = stop; bits 6:0 = sample or piece number |
| voice_busy | input | 4 | Live busy status, bit i = voice i+1 |
| ready | output | 1 | Idle; a request is accepted on this edge |
| wr_en | output | 1 | Write strobe to the playback device |
| wr_data | output | 8 | Write byte |
| tick | output | 1 | One-cycle sequencing tick |
| track_no | output | 7 | Number of the piece now playing |
| bar_no | output | 8 | Bar register |

## Verification
The assertions assume that `req_code` and `req_track` are stable while `req_valid` is high on an accepting edge. They also assume that TICK_PERIOD_CYC is at least 2, so two ticks never fall on adjacent cycles. The bench drives each request for one cycle, or for longer when it deliberately holds `req_valid` through a busy burst. It changes `voice_busy` only at the falling edge, which lets both the checker and the model see one value per edge. The bench shortens the tick parameters so that several ticks fall within the run.

// File: rtl/snd_dispatch_pkg.sv
package snd_dispatch_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_W    = 7;
  localparam int SEQ_MAX  = 3;
  localparam int FX_VOICES = 3;

  localparam logic [BYTE_W-1:0] PLAY_BASE   = 8'h80;
  localparam logic [BYTE_W-1:0] MUSIC_VOICE = 8'h81;
  localparam logic [BYTE_W-1:0] HALT_V4     = 8'h40;
  localparam logic [3:0]        VOICE_LOW   = 4'h1;

  typedef enum logic [1:0] {
    REQ_NONE,
    REQ_STOP,
    REQ_EFFECT,
    REQ_MUSIC
  } req_kind_e;
endpackage

// File: rtl/snd_voice_pick.sv
module snd_voice_pick #(
  parameter int NV = 3
) (
  input  logic [NV-1:0] busy,
  output logic [NV-1:0] grant,
  output logic          found
);
  logic [NV:0] all_busy_below;

  assign all_busy_below[0] = 1'b1;

  genvar gi;
  generate
    for (gi = 0; gi < NV; gi++) begin : g_prio
      assign grant[gi]            = all_busy_below[gi] & ~busy[gi];
      assign all_busy_below[gi+1] = all_busy_below[gi] & busy[gi];
    end
  endgenerate

  assign found = ~all_busy_below[NV];
endmodule

// File: rtl/snd_write_seq.sv
module snd_write_seq #(
  parameter int DEPTH = 3,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CW-1:0]    load_cnt,
  input  logic [DEPTH*W-1:0] load_bytes,
  output logic             idle,
  output logic             wr_en,
  output logic [W-1:0]     wr_data
);
  logic [DEPTH-1:0][W-1:0] buf_q, buf_d;
  logic [CW-1:0]           cnt_q, cnt_d;
  logic                    upd;

  assign idle    = (cnt_q == '0);
  assign wr_en   = ~idle;
  assign wr_data = buf_q[0];

  always_comb begin
    buf_d = buf_q;
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (load && idle) begin
      upd = 1'b1;
      cnt_d = load_cnt;
      for (int i = 0; i < DEPTH; i++) buf_d[i] = load_bytes[i*W +: W];
    end else if (!idle) begin
      upd = 1'b1;
      cnt_d = cnt_q - 1'b1;
      for (int i = 0; i < DEPTH - 1; i++) buf_d[i] = buf_q[i+1];
      buf_d[DEPTH-1] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      buf_q <= buf_d;
    end
  end
endmodule

// File: rtl/snd_tick_gen.sv
module snd_tick_gen #(
  parameter int FIRST  = 800000,
  parameter int PERIOD = 800000,
  localparam int MAXV  = (FIRST > PERIOD) ? FIRST : PERIOD,
  localparam int CW    = $clog2(MAXV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic halt,
  output logic tick
);
  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  assign tick = run_q && (cnt_q == '0);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (start) begin
      upd   = 1'b1;
      run_d = 1'b1;
      cnt_d = CW'(FIRST - 1);
    end else if (halt) begin
      upd   = 1'b1;
      run_d = 1'b0;
      cnt_d = '0;
    end else if (run_q) begin
      upd   = 1'b1;
      cnt_d = (cnt_q == '0) ? CW'(PERIOD - 1) : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/snd_voice_dispatch.sv
module snd_voice_dispatch
  import snd_dispatch_pkg::*;
#(
  parameter int FIRST_TICK_CYC  = 800000,
  parameter int TICK_PERIOD_CYC = 800000,
  parameter int BAR_W           = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_track,
  input  logic [7:0]       req_code,
  input  logic [3:0]       voice_busy,
  output logic             ready,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             tick,
  output logic [NUM_W-1:0] track_no,
  output logic [BAR_W-1:0] bar_no
);
  localparam int CW = $clog2(SEQ_MAX + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic                    accept;
  req_kind_e               kind;
  logic [NUM_W-1:0]        num;
  logic [BYTE_W-1:0]       play_byte;
  logic [FX_VOICES-1:0]    fx_grant;
  logic                    fx_found;
  logic                    same_track;
  logic [SEQ_MAX*BYTE_W-1:0] seq_bytes;
  logic [CW-1:0]           seq_cnt;
  logic                    seq_load;
  logic                    seq_idle;
  logic                    music_go, music_halt;
  logic [NUM_W-1:0]        track_q, track_d;
  logic [BAR_W-1:0]        bar_q, bar_d;
  logic                    reg_upd;

  assign ready     = seq_idle;
  assign accept    = req_valid && seq_idle;
  assign num       = req_code[NUM_W-1:0];
  assign play_byte = PLAY_BASE | {1'b0, num};
  assign same_track = (num == track_q);

  always_comb begin
    if (!accept)          kind = REQ_NONE;
    else if (req_code[7]) kind = REQ_STOP;
    else if (req_track)   kind = REQ_MUSIC;
    else                  kind = REQ_EFFECT;
  end

  snd_voice_pick #(.NV(FX_VOICES)) u_pick (
    .busy  (voice_busy[FX_VOICES-1:0]),
    .grant (fx_grant),
    .found (fx_found)
  );

  always_comb begin
    seq_bytes  = '0;
    seq_cnt    = '0;
    music_go   = 1'b0;
    music_halt = 1'b0;
    unique case (kind)
      REQ_STOP: begin
        seq_bytes[0 +: BYTE_W] = {1'b0, num};
        seq_cnt    = CW'(1);
        music_halt = req_track;
      end
      REQ_EFFECT: begin
        if (fx_found) begin
          seq_bytes[0 +: BYTE_W]      = play_byte;
          seq_bytes[BYTE_W +: BYTE_W] = {1'b0, fx_grant, VOICE_LOW};
          seq_cnt = CW'(2);
        end
      end
      REQ_MUSIC: begin
        if (!same_track) begin
          music_go = 1'b1;
          if (voice_busy[3]) begin
            seq_bytes[0 +: BYTE_W]        = HALT_V4;
            seq_bytes[BYTE_W +: BYTE_W]   = play_byte;
            seq_bytes[2*BYTE_W +: BYTE_W] = MUSIC_VOICE;
            seq_cnt = CW'(3);
          end else begin
            seq_bytes[0 +: BYTE_W]      = play_byte;
            seq_bytes[BYTE_W +: BYTE_W] = MUSIC_VOICE;
            seq_cnt = CW'(2);
          end
        end
      end
      default: ;
    endcase
  end

  assign seq_load = (seq_cnt != '0);

  snd_write_seq #(.DEPTH(SEQ_MAX), .W(BYTE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (seq_load),
    .load_cnt   (seq_cnt),
    .load_bytes (seq_bytes),
    .idle       (seq_idle),
    .wr_en      (wr_en),
    .wr_data    (wr_data)
  );

  snd_tick_gen #(.FIRST(FIRST_TICK_CYC), .PERIOD(TICK_PERIOD_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (music_go),
    .halt  (music_halt),
    .tick  (tick)
  );

  always_comb begin
    track_d = track_q;
    bar_d   = bar_q;
    reg_upd = music_go | music_halt;
    if (music_go) begin
      track_d = num;
      bar_d   = BAR_W'(1);
    end else if (music_halt) begin
      track_d = '0;
      bar_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      track_q <= '0;
      bar_q   <= '0;
    end else if (reg_upd) begin
      track_q <= track_d;
      bar_q   <= bar_d;
    end
  end

  assign track_no = track_q;
  assign bar_no   = bar_q;
endmodule

// File: rtl/snd_voice_dispatch_chk.sv
module snd_voice_dispatch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_track,
  input logic [7:0] req_code,
  input logic [3:0] voice_busy,
  input logic       ready,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       tick,
  input logic [6:0] track_no,
  input logic [7:0] bar_no
);
  // R2
  stop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && req_code[7]) |=> (wr_en && wr_data == {1'b0, $past(req_code[6:0])}));

  // R3
  fx_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && !req_code[7] && !req_track && !(&voice_busy[2:0]))
      |=> (wr_en && wr_data == {1'b1, $past(req_code[6:0])}));

  // R4
  fx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && !req_code[7] && !req_track && (&voice_busy[2:0]))
      |=> (ready && !wr_en));

  // R6
  same_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && !req_code[7] && req_track && req_code[6:0] == track_no)
      |=> (ready && !wr_en && $stable(track_no) && $stable(bar_no)));

  // R7
  music_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && req_code[7] && req_track)
      |=> (track_no == 7'd0 && bar_no == 8'd0 && !tick));

  // R8
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !ready);
endmodule

bind snd_voice_dispatch snd_voice_dispatch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_track  (req_track),
  .req_code   (req_code),
  .voice_busy (voice_busy),
  .ready      (ready),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .tick       (tick),
  .track_no   (track_no),
  .bar_no     (bar_no)
);

// File: tb/snd_voice_dispatch_tb.sv
module snd_voice_dispatch_tb;
  localparam int F = 20;
  localparam int P = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_track = 1'b0;
  logic [7:0] req_code = 8'h00;
  logic [3:0] voice_busy = 4'h0;
  logic       ready, wr_en, tick;
  logic [7:0] wr_data;
  logic [6:0] track_no;
  logic [7:0] bar_no;

  always #2.5 clk = ~clk;

  snd_voice_dispatch #(.FIRST_TICK_CYC(F), .TICK_PERIOD_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_track(req_track),
    .req_code(req_code), .voice_busy(voice_busy), .ready(ready), .wr_en(wr_en),
    .wr_data(wr_data), .tick(tick), .track_no(track_no), .bar_no(bar_no)
  );

  int    n_run = 0, n_fail = 0, n_wr = 0, cyc = 0;
  string cur_req = "R1";
  logic  done = 1'b0;

  // behavioural reference
  logic [7:0] exp_q[$];
  int  m_track = 0, m_bar = 0, m_cnt = 0;
  bit  m_run = 0;
  logic [7:0] wr_log[$];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      exp_q.delete(); m_track = 0; m_bar = 0; m_run = 0; m_cnt = 0;
    end else begin
      bit acc;
      int n;
      acc = req_valid && (exp_q.size() == 0);
      if (exp_q.size() != 0) void'(exp_q.pop_front());
      if (m_run) m_cnt = (m_cnt == 0) ? P - 1 : m_cnt - 1;
      if (acc) begin
        n = req_code[6:0];
        if (req_code[7]) begin
          exp_q.push_back({1'b0, req_code[6:0]});
          if (req_track) begin m_run = 0; m_track = 0; m_bar = 0; end
        end else if (!req_track) begin
          if (!voice_busy[0])      begin exp_q.push_back(8'h80 + n); exp_q.push_back(8'h11); end
          else if (!voice_busy[1]) begin exp_q.push_back(8'h80 + n); exp_q.push_back(8'h21); end
          else if (!voice_busy[2]) begin exp_q.push_back(8'h80 + n); exp_q.push_back(8'h41); end
        end else if (n != m_track) begin
          if (voice_busy[3]) exp_q.push_back(8'h40);
          exp_q.push_back(8'h80 + n);
          exp_q.push_back(8'h81);
          m_track = n; m_bar = 1; m_run = 1; m_cnt = F - 1;
        end
      end
    end
    if (cyc > 20000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: %s run did not end, actual cyc=%0d expected <20000", cur_req, cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (wr_en) wr_log.push_back(wr_data);
    chk("R9", "ready", ready, exp_q.size() == 0);
    chk(cur_req, "wr_en", wr_en, exp_q.size() != 0);
    if (exp_q.size() != 0) chk(cur_req, "wr_data", wr_data, exp_q[0]);
    chk("R8", "tick", tick, m_run && m_cnt == 0);
    chk(cur_req, "track_no", track_no, m_track);
    chk(cur_req, "bar_no", bar_no, m_bar);
  end

  task automatic send(bit trk, logic [7:0] code, logic [3:0] st);
    @(negedge clk); #1;
    while (!ready) begin @(negedge clk); #1; end
    req_valid = 1'b1; req_track = trk; req_code = code; voice_busy = st;
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_log(string tag, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, int cnt);
    settle(6);
    chk(tag, "write count", wr_log.size(), cnt);
    if (cnt > 0 && wr_log.size() > 0) chk(tag, "byte0", wr_log[0], b0);
    if (cnt > 1 && wr_log.size() > 1) chk(tag, "byte1", wr_log[1], b1);
    if (cnt > 2 && wr_log.size() > 2) chk(tag, "byte2", wr_log[2], b2);
    wr_log.delete();
  endtask

  initial begin
    settle(3);
    chk("R1", "reset ready", ready, 1);
    chk("R1", "reset wr_en", wr_en, 0);
    chk("R1", "reset tick", tick, 0);
    chk("R1", "reset track", track_no, 0);
    chk("R1", "reset bar", bar_no, 0);
    @(negedge clk); #1; rst_n = 1'b1;
    settle(5);

    cur_req = "R3";
    send(0, 8'h05, 4'b0000); expect_log("R3", 8'h85, 8'h11, 0, 2);
    send(0, 8'h12, 4'b0001); expect_log("R3", 8'h92, 8'h21, 0, 2);
    send(0, 8'h7F, 4'b1011); expect_log("R3", 8'hFF, 8'h41, 0, 2);
    send(0, 8'h33, 4'b0110); expect_log("R3", 8'hB3, 8'h11, 0, 2);

    cur_req = "R4";
    send(0, 8'h22, 4'b0111); expect_log("R4", 0, 0, 0, 0);
    send(0, 8'h22, 4'b1111); expect_log("R4", 0, 0, 0, 0);

    cur_req = "R2";
    send(0, 8'h83, 4'b1111); expect_log("R2", 8'h03, 0, 0, 1);

    cur_req = "R5";
    send(1, 8'h09, 4'b0000); expect_log("R5", 8'h89, 8'h81, 0, 2);
    chk("R5", "track", track_no, 9); chk("R5", "bar", bar_no, 1);
    settle(70);

    cur_req = "R6";
    send(1, 8'h09, 4'b1000); expect_log("R6", 0, 0, 0, 0);
    chk("R6", "track kept", track_no, 9);
    settle(40);

    cur_req = "R5";
    send(1, 8'h2A, 4'b1000); expect_log("R5", 8'h40, 8'hAA, 8'h81, 3);
    settle(80);

    cur_req = "R10";
    @(negedge clk); #1;
    req_valid = 1'b1; req_track = 1'b0; req_code = 8'h11; voice_busy = 4'b0011;
    @(negedge clk); #1;
    req_valid = 1'b0; voice_busy = 4'b0000;
    expect_log("R10", 8'h91, 8'h41, 0, 2);

    cur_req = "R9";
    @(negedge clk); #1;
    req_valid = 1'b1; req_track = 1'b1; req_code = 8'h44; voice_busy = 4'b0000;
    @(negedge clk); #1;
    req_code = 8'h85; req_track = 1'b0;
    @(negedge clk); #1;
    req_valid = 1'b0;
    expect_log("R9", 8'hC4, 8'h81, 0, 2);
    chk("R9", "track after held req", track_no, 8'h44);
    settle(50);

    cur_req = "R7";
    send(1, 8'h80, 4'b1000); expect_log("R7", 8'h00, 0, 0, 1);
    chk("R7", "track cleared", track_no, 0); chk("R7", "bar cleared", bar_no, 0);
    settle(70);

    cur_req = "R6";
    send(1, 8'h00, 4'b0000); expect_log("R6", 0, 0, 0, 0);
    settle(40);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule